// File: doc/BRIEF.md
# Sixteen-Bit Timer With Three Compare Channels

This block is a 16-bit counter that advances once per qualified count tick and
drives three output-compare channels. A 4-bit mode input selects both how the
counter moves and where its upper limit (TOP) comes from. TOP can be a fixed
8-, 9- or 10-bit all-ones value, the active value of compare channel A, or a
separately loaded capture register. The counter runs in four waveform styles:
free-running, restart on reaching TOP, single-slope PWM and dual-slope
(up/down) PWM.

Each channel keeps a written (buffered) compare value and an active compare
value. When the counter equals the active value on a tick, the channel raises a
sticky match flag and updates its output pin according to the waveform style.
In the PWM styles the buffered value moves to the active register only at the
cycle boundary. This keeps duty-cycle changes free of glitches. An overflow flag
marks the end of each counting cycle. The count value, the compare values and
the capture register are all loaded through plain parallel write ports, and
every flag is cleared by pulsing its bit on a clear input.

Top module: `tmr16_unit`

## Requirements
- R1: The counter changes only on a cycle where both `src_en_i` and `tick_i` are high, or where `cnt_ld_i` is high. With `src_en_i` low, `tick_i` has no effect on the count, flags or outputs.
- R2: `mode_i` encoding: 0 free-running; 1 restart with TOP = channel A; 2 restart with TOP = capture register; 3/4/5 single-slope PWM with TOP = 0x00FF/0x01FF/0x03FF; 6 single-slope PWM with TOP = channel A; 7 single-slope PWM with TOP = capture register; 8/9/10 dual-slope PWM with TOP = 0x00FF/0x01FF/0x03FF; 11 dual-slope PWM with TOP = channel A; 12 dual-slope PWM with TOP = capture register; 13 to 15 behave as 0.
- R3: In mode 0 the counter steps from 0xFFFF to 0x0000 and sets `tov_o` on that step.
- R4: In modes 1 and 2, a tick taken with the counter equal to TOP reloads it to 0x0000. `tov_o` sets only when a tick is taken at 0xFFFF.
- R5: A tick taken while the count equals a channel's active compare value sets that channel's bit of `ocf_o` (bit 0 = A, 1 = B, 2 = C). Flags stay set until the matching `flag_clr_i` bit (0 to 2 for the channels, 3 for `tov_o`) is high. A new set in the same cycle wins over a clear.
- R6: In modes 0 to 2, a compare write takes effect on the next cycle, and a match toggles that channel's output.
- R7: In single-slope PWM, a tick at or above TOP restarts the count at 0x0000, sets `tov_o`, sets every channel output high and moves buffered compare values to active. Otherwise a match drives the output low.
- R8: In dual-slope PWM, the counter counts up to TOP, then down to 0x0000. `down_o` is high while it counts down. A tick at 0x0000 sets `tov_o` and moves buffered compare values to active. A match while counting up drives the output low, and a match while counting down drives it high.
- R9: In modes 6 and 11, channel A's output stays low. Its match flag still works.
- R10: `cnt_ld_i` loads `cnt_ld_val_i` into the counter and overrides a tick in the same cycle.
- R11: After reset the count, direction, all flags, all outputs and all compare and capture registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_en_i | input | 1 | Count source selected |
| tick_i | input | 1 | Count-enable tick |
| mode_i | input | 4 | Mode select (see R2) |
| cnt_ld_i | input | 1 | Load counter |
| cnt_ld_val_i | input | 16 | Counter load value |
| ocr_wr_i | input | 3 | Per-channel compare write strobes |
| ocr_wdata_i | input | 16 | Compare write data |
| icr_wr_i | input | 1 | Capture register write strobe |
| icr_wdata_i | input | 16 | Capture register write data |
| flag_clr_i | input | 4 | Flag clear, bits 0-2 match, bit 3 overflow |
| cnt_o | output | 16 | Current count |
| down_o | output | 1 | Counting down (dual-slope) |
| ocf_o | output | 3 | Match flags A, B, C |
| tov_o | output | 1 | Overflow flag |
| oc_o | output | 3 | Compare outputs A, B, C |

## Verification
On every cycle, properties check the following: the count holds when no source is selected, the restart and PWM wrap points return the count to zero, the dual-slope counter turns around at a fixed TOP, flags stay set unless cleared, and channel A stays low while it serves as TOP. The exact waveform on each output pin, the placement of the transfer from buffered to active compare values (at TOP or at BOTTOM, never mid-period) and the selection of each fixed limit can only be seen in the bench's tick sequences. Those sequences compare the count, outputs and flags against values worked out by hand.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    typedef enum logic [3:0] {
        MD_NORMAL   = 4'd0,
        MD_CTC_A    = 4'd1,
        MD_CTC_C    = 4'd2,
        MD_FAST_8   = 4'd3,
        MD_FAST_9   = 4'd4,
        MD_FAST_10  = 4'd5,
        MD_FAST_A   = 4'd6,
        MD_FAST_C   = 4'd7,
        MD_PHASE_8  = 4'd8,
        MD_PHASE_9  = 4'd9,
        MD_PHASE_10 = 4'd10,
        MD_PHASE_A  = 4'd11,
        MD_PHASE_C  = 4'd12
    } tmr_mode_e;

    typedef enum logic [1:0] {
        WV_PLAIN = 2'd0,
        WV_FAST  = 2'd1,
        WV_PHASE = 2'd2
    } wave_e;

endpackage

// File: rtl/tmr16_top_sel.sv
module tmr16_top_sel
    import tmr16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [3:0]       mode_i,
    input  logic [CNT_W-1:0] lim_a_i,
    input  logic [CNT_W-1:0] lim_c_i,
    output logic [CNT_W-1:0] top_o,
    output wave_e            wave_o,
    output logic             a_is_top_o
);
    localparam logic [CNT_W-1:0] LIM_MAX = '1;
    localparam logic [CNT_W-1:0] LIM_8   = CNT_W'((1 << 8) - 1);
    localparam logic [CNT_W-1:0] LIM_9   = CNT_W'((1 << 9) - 1);
    localparam logic [CNT_W-1:0] LIM_10  = CNT_W'((1 << 10) - 1);

    always_comb begin
        top_o      = LIM_MAX;
        wave_o     = WV_PLAIN;
        a_is_top_o = 1'b0;
        case (mode_i)
            MD_CTC_A:    top_o = lim_a_i;
            MD_CTC_C:    top_o = lim_c_i;
            MD_FAST_8:   begin top_o = LIM_8;   wave_o = WV_FAST; end
            MD_FAST_9:   begin top_o = LIM_9;   wave_o = WV_FAST; end
            MD_FAST_10:  begin top_o = LIM_10;  wave_o = WV_FAST; end
            MD_FAST_A:   begin top_o = lim_a_i; wave_o = WV_FAST; a_is_top_o = 1'b1; end
            MD_FAST_C:   begin top_o = lim_c_i; wave_o = WV_FAST; end
            MD_PHASE_8:  begin top_o = LIM_8;   wave_o = WV_PHASE; end
            MD_PHASE_9:  begin top_o = LIM_9;   wave_o = WV_PHASE; end
            MD_PHASE_10: begin top_o = LIM_10;  wave_o = WV_PHASE; end
            MD_PHASE_A:  begin top_o = lim_a_i; wave_o = WV_PHASE; a_is_top_o = 1'b1; end
            MD_PHASE_C:  begin top_o = lim_c_i; wave_o = WV_PHASE; end
            default: ;
        endcase
    end

endmodule

// File: rtl/tmr16_count.sv
module tmr16_count
    import tmr16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  wave_e            wave_i,
    input  logic [CNT_W-1:0] top_i,
    input  logic             ld_i,
    input  logic [CNT_W-1:0] ld_val_i,
    input  logic             tov_clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             down_o,
    output logic             tov_o,
    output logic             wrap_evt_o,
    output logic             bot_evt_o
);
    localparam logic [CNT_W-1:0] ZERO    = '0;
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
        logic             tov;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    at_top;
    logic    tov_set;

    always_comb begin
        st_d       = st_q;
        tov_set    = 1'b0;
        at_top     = (st_q.cnt >= top_i);
        wrap_evt_o = step_i && (wave_i == WV_FAST) && at_top;
        bot_evt_o  = step_i && (wave_i == WV_PHASE) && (st_q.cnt == ZERO);

        if (step_i) begin
            case (wave_i)
                WV_FAST: begin
                    st_d.cnt = at_top ? ZERO : st_q.cnt + ONE;
                    tov_set  = at_top;
                end
                WV_PHASE: begin
                    if (st_q.cnt == ZERO) begin
                        st_d.down = 1'b0;
                        st_d.cnt  = (top_i == ZERO) ? ZERO : ONE;
                        tov_set   = 1'b1;
                    end else if (!st_q.down && at_top) begin
                        st_d.down = 1'b1;
                        st_d.cnt  = st_q.cnt - ONE;
                    end else if (st_q.down) begin
                        st_d.cnt  = st_q.cnt - ONE;
                    end else begin
                        st_d.cnt  = st_q.cnt + ONE;
                    end
                end
                default: begin
                    st_d.cnt = (st_q.cnt == top_i) ? ZERO : st_q.cnt + ONE;
                    tov_set  = (st_q.cnt == CNT_MAX);
                end
            endcase
        end

        if (wave_i != WV_PHASE) begin
            st_d.down = 1'b0;
        end
        if (ld_i) begin
            st_d.cnt = ld_val_i;
        end
        st_d.tov = (st_q.tov && !tov_clr_i) || tov_set;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign down_o = st_q.down;
    assign tov_o  = st_q.tov;

endmodule

// File: rtl/tmr16_chan.sv
module tmr16_chan
    import tmr16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             down_i,
    input  wave_e            wave_i,
    input  logic             wrap_evt_i,
    input  logic             bot_evt_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             clr_i,
    input  logic             hold_low_i,
    output logic [CNT_W-1:0] act_o,
    output logic             flag_o,
    output logic             oc_o
);
    typedef struct packed {
        logic [CNT_W-1:0] pend;
        logic [CNT_W-1:0] act;
        logic             flag;
        logic             oc;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic   hit;

    always_comb begin
        st_d      = st_q;
        hit       = step_i && (cnt_i == st_q.act);
        st_d.pend = wr_i ? wdata_i : st_q.pend;

        case (wave_i)
            WV_FAST: begin
                if (wrap_evt_i) st_d.act = st_d.pend;
                if (wrap_evt_i)  st_d.oc = 1'b1;
                else if (hit)    st_d.oc = 1'b0;
            end
            WV_PHASE: begin
                if (bot_evt_i) st_d.act = st_d.pend;
                if (hit)       st_d.oc  = down_i;
            end
            default: begin
                if (wr_i) st_d.act = wdata_i;
                if (hit)  st_d.oc  = !st_q.oc;
            end
        endcase

        if (hold_low_i) begin
            st_d.oc = 1'b0;
        end
        st_d.flag = (st_q.flag && !clr_i) || hit;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_o  = st_q.act;
    assign flag_o = st_q.flag;
    assign oc_o   = st_q.oc;

endmodule

// File: rtl/tmr16_unit.sv
module tmr16_unit
    import tmr16_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              src_en_i,
    input  logic              tick_i,
    input  logic [3:0]        mode_i,
    input  logic              cnt_ld_i,
    input  logic [CNT_W-1:0]  cnt_ld_val_i,
    input  logic [NUM_CH-1:0] ocr_wr_i,
    input  logic [CNT_W-1:0]  ocr_wdata_i,
    input  logic              icr_wr_i,
    input  logic [CNT_W-1:0]  icr_wdata_i,
    input  logic [NUM_CH:0]   flag_clr_i,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              down_o,
    output logic [NUM_CH-1:0] ocf_o,
    output logic              tov_o,
    output logic [NUM_CH-1:0] oc_o
);
    localparam int TOV_BIT = NUM_CH;

    logic             step;
    logic [CNT_W-1:0] icr_d, icr_q;
    logic [CNT_W-1:0] top;
    wave_e            wave;
    logic             a_is_top;
    logic             wrap_evt, bot_evt;
    logic [CNT_W-1:0] act [NUM_CH];

    always_comb begin
        step  = src_en_i && tick_i;
        icr_d = icr_wr_i ? icr_wdata_i : icr_q;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            icr_q <= '0;
        end else begin
            icr_q <= icr_d;
        end
    end

    tmr16_top_sel #(.CNT_W(CNT_W)) top_sel_i (
        .mode_i     (mode_i),
        .lim_a_i    (act[0]),
        .lim_c_i    (icr_q),
        .top_o      (top),
        .wave_o     (wave),
        .a_is_top_o (a_is_top)
    );

    tmr16_count #(.CNT_W(CNT_W)) count_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .step_i     (step),
        .wave_i     (wave),
        .top_i      (top),
        .ld_i       (cnt_ld_i),
        .ld_val_i   (cnt_ld_val_i),
        .tov_clr_i  (flag_clr_i[TOV_BIT]),
        .cnt_o      (cnt_o),
        .down_o     (down_o),
        .tov_o      (tov_o),
        .wrap_evt_o (wrap_evt),
        .bot_evt_o  (bot_evt)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hold_low;
        if (g == 0) begin : g_a
            assign hold_low = a_is_top;
        end else begin : g_other
            assign hold_low = 1'b0;
        end

        tmr16_chan #(.CNT_W(CNT_W)) chan_i (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .step_i     (step),
            .cnt_i      (cnt_o),
            .down_i     (down_o),
            .wave_i     (wave),
            .wrap_evt_i (wrap_evt),
            .bot_evt_i  (bot_evt),
            .wr_i       (ocr_wr_i[g]),
            .wdata_i    (ocr_wdata_i),
            .clr_i      (flag_clr_i[g]),
            .hold_low_i (hold_low),
            .act_o      (act[g]),
            .flag_o     (ocf_o[g]),
            .oc_o       (oc_o[g])
        );
    end

endmodule

// File: rtl/tmr16_unit_chk.sv
module tmr16_unit_chk
    import tmr16_pkg::*;
(
    input logic        clk_i,
    input logic        rst_ni,
    input logic        src_en_i,
    input logic        tick_i,
    input logic [3:0]  mode_i,
    input logic        cnt_ld_i,
    input logic        icr_wr_i,
    input logic [15:0] icr_wdata_i,
    input logic [3:0]  flag_clr_i,
    input logic [15:0] cnt_o,
    input logic        down_o,
    input logic [2:0]  ocf_o,
    input logic        tov_o,
    input logic [2:0]  oc_o
);
    logic [15:0] cap_q;
    logic        a_top_mode;

    always_ff @(posedge clk_i) begin
        if (!rst_ni)       cap_q <= '0;
        else if (icr_wr_i) cap_q <= icr_wdata_i;
    end

    assign a_top_mode = (mode_i == MD_FAST_A) || (mode_i == MD_PHASE_A);

    AST_HOLD_NO_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!src_en_i && !cnt_ld_i) |=> $stable(cnt_o)); // R1

    AST_CTC_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MD_CTC_C && src_en_i && tick_i && !cnt_ld_i && cnt_o == cap_q)
        |=> (cnt_o == 16'h0000)); // R4

    AST_FAST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MD_FAST_8 && src_en_i && tick_i && !cnt_ld_i && cnt_o == 16'h00FF)
        |=> (cnt_o == 16'h0000 && tov_o)); // R7

    AST_PHASE_TURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MD_PHASE_8 && src_en_i && tick_i && !cnt_ld_i && !down_o && cnt_o == 16'h00FF)
        |=> (down_o && cnt_o == 16'h00FE)); // R8

    AST_MATCH_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(ocf_o & ~flag_clr_i[2:0]))
        |=> ((ocf_o & $past(ocf_o & ~flag_clr_i[2:0])) == $past(ocf_o & ~flag_clr_i[2:0]))); // R5

    AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tov_o && !flag_clr_i[3]) |=> tov_o); // R5

    AST_A_HELD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (a_top_mode && $past(a_top_mode)) |-> !oc_o[0]); // R9

endmodule

bind tmr16_unit tmr16_unit_chk chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_en_i    (src_en_i),
    .tick_i      (tick_i),
    .mode_i      (mode_i),
    .cnt_ld_i    (cnt_ld_i),
    .icr_wr_i    (icr_wr_i),
    .icr_wdata_i (icr_wdata_i),
    .flag_clr_i  (flag_clr_i),
    .cnt_o       (cnt_o),
    .down_o      (down_o),
    .ocf_o       (ocf_o),
    .tov_o       (tov_o),
    .oc_o        (oc_o)
);

// File: tb/tmr16_unit_tb_top.sv
module tmr16_unit_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        src_en_i = 1'b0;
    logic        tick_i = 1'b0;
    logic [3:0]  mode_i = 4'd0;
    logic        cnt_ld_i = 1'b0;
    logic [15:0] cnt_ld_val_i = '0;
    logic [2:0]  ocr_wr_i = '0;
    logic [15:0] ocr_wdata_i = '0;
    logic        icr_wr_i = 1'b0;
    logic [15:0] icr_wdata_i = '0;
    logic [3:0]  flag_clr_i = '0;
    logic [15:0] cnt_o;
    logic        down_o;
    logic [2:0]  ocf_o;
    logic        tov_o;
    logic [2:0]  oc_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk_i = ~clk_i;

    tmr16_unit dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .src_en_i(src_en_i), .tick_i(tick_i),
        .mode_i(mode_i), .cnt_ld_i(cnt_ld_i), .cnt_ld_val_i(cnt_ld_val_i),
        .ocr_wr_i(ocr_wr_i), .ocr_wdata_i(ocr_wdata_i), .icr_wr_i(icr_wr_i),
        .icr_wdata_i(icr_wdata_i), .flag_clr_i(flag_clr_i), .cnt_o(cnt_o),
        .down_o(down_o), .ocf_o(ocf_o), .tov_o(tov_o), .oc_o(oc_o)
    );

    typedef struct packed {
        logic [3:0]  mode;
        logic [15:0] a, b, c, cap, start, n, e_cnt;
        logic [2:0]  e_oc, e_ocf;
        logic        e_tov, e_down;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    // outputs are compared as {cnt, oc, ocf, tov, down}
    localparam vec_t VECS [NV] = '{
        '{4'd0,  16'h0005, 16'h000A, 16'h8000, 16'h0000, 16'h0000, 16'd8, 16'h0008, 3'b001, 3'b001, 1'b0, 1'b0, 4'd6},  // R6
        '{4'd0,  16'hFFFF, 16'h0000, 16'h0001, 16'h0000, 16'hFFFE, 16'd3, 16'h0001, 3'b011, 3'b011, 1'b1, 1'b0, 4'd3},  // R3
        '{4'd1,  16'h0004, 16'h0002, 16'h0007, 16'h0000, 16'h0000, 16'd7, 16'h0002, 3'b011, 3'b011, 1'b0, 1'b0, 4'd4},  // R4
        '{4'd2,  16'h0001, 16'h0003, 16'h0009, 16'h0003, 16'h0000, 16'd9, 16'h0001, 3'b000, 3'b011, 1'b0, 1'b0, 4'd4},  // R4
        '{4'd3,  16'h0010, 16'h00FF, 16'h0200, 16'h0000, 16'h00FE, 16'd3, 16'h0001, 3'b111, 3'b010, 1'b1, 1'b0, 4'd7},  // R7
        '{4'd3,  16'h0002, 16'h0000, 16'h0005, 16'h0000, 16'h00FF, 16'd5, 16'h0004, 3'b100, 3'b011, 1'b1, 1'b0, 4'd7},  // R7
        '{4'd4,  16'h0003, 16'h01FF, 16'h0100, 16'h0000, 16'h01FF, 16'd1, 16'h0000, 3'b111, 3'b010, 1'b1, 1'b0, 4'd2},  // R2
        '{4'd5,  16'h0200, 16'h03FF, 16'h0000, 16'h0000, 16'h03FE, 16'd3, 16'h0001, 3'b011, 3'b110, 1'b1, 1'b0, 4'd2},  // R2
        '{4'd6,  16'h0005, 16'h0002, 16'h0009, 16'h0000, 16'h0000, 16'd8, 16'h0002, 3'b110, 3'b011, 1'b1, 1'b0, 4'd9},  // R9
        '{4'd7,  16'h0001, 16'h0006, 16'h0004, 16'h0004, 16'h0000, 16'd6, 16'h0001, 3'b111, 3'b101, 1'b1, 1'b0, 4'd7},  // R7
        '{4'd8,  16'h00FE, 16'h0010, 16'h00FF, 16'h0000, 16'h00FD, 16'd5, 16'h00FC, 3'b001, 3'b101, 1'b0, 1'b1, 4'd8},  // R8
        '{4'd11, 16'h0003, 16'h0001, 16'h0002, 16'h0000, 16'h0000, 16'd7, 16'h0001, 3'b110, 3'b111, 1'b1, 1'b0, 4'd9},  // R9
        '{4'd12, 16'h0000, 16'h0005, 16'h0002, 16'h0002, 16'h0002, 16'd3, 16'h0001, 3'b001, 3'b101, 1'b1, 1'b0, 4'd8},  // R8
        '{4'd10, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h03FF, 16'd1, 16'h03FE, 3'b000, 3'b000, 1'b0, 1'b1, 4'd2}   // R2
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] snap();
        return 64'({cnt_o, oc_o, ocf_o, tov_o, down_o});
    endfunction

    task automatic do_reset();
        rst_ni = 1'b0;
        repeat (2) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
    endtask

    task automatic tick_n(input int n);
        src_en_i = 1'b1;
        tick_i   = 1'b1;
        repeat (n) @(negedge clk_i);
        tick_i   = 1'b0;
    endtask

    task automatic wr_ocr(input int ch, input logic [15:0] v);
        ocr_wr_i    = 3'(1 << ch);
        ocr_wdata_i = v;
        @(negedge clk_i);
        ocr_wr_i    = '0;
    endtask

    task automatic load_cnt(input logic [15:0] v);
        cnt_ld_i     = 1'b1;
        cnt_ld_val_i = v;
        @(negedge clk_i);
        cnt_ld_i     = 1'b0;
    endtask

    task automatic pulse_clr(input logic [3:0] m);
        flag_clr_i = m;
        @(negedge clk_i);
        flag_clr_i = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R11: reset state
        check("R11 reset", snap(), 64'({16'h0, 3'b000, 3'b000, 1'b0, 1'b0}));

        for (int i = 0; i < NV; i++) begin
            do_reset();
            mode_i = 4'd0;
            wr_ocr(0, VECS[i].a);
            wr_ocr(1, VECS[i].b);
            wr_ocr(2, VECS[i].c);
            icr_wr_i = 1'b1; icr_wdata_i = VECS[i].cap;
            @(negedge clk_i);
            icr_wr_i = 1'b0;
            load_cnt(VECS[i].start);
            mode_i = VECS[i].mode;
            tick_n(int'(VECS[i].n));
            check($sformatf("vector %0d R%0d", i, VECS[i].req), snap(),
                  64'({VECS[i].e_cnt, VECS[i].e_oc, VECS[i].e_ocf, VECS[i].e_tov, VECS[i].e_down}));
        end

        // R1: ticks ignored with no source; source without tick also holds
        do_reset();
        mode_i = 4'd0;
        load_cnt(16'h0010);
        src_en_i = 1'b0; tick_i = 1'b1;
        repeat (5) @(negedge clk_i);
        tick_i = 1'b0;
        check("R1 no source", snap(), 64'({16'h0010, 3'b000, 3'b000, 1'b0, 1'b0}));
        src_en_i = 1'b1;
        repeat (3) @(negedge clk_i);
        check("R1 no tick", 64'(cnt_o), 64'h0010);

        // R10: load beats a tick in the same cycle
        tick_i = 1'b1; cnt_ld_i = 1'b1; cnt_ld_val_i = 16'h1234;
        @(negedge clk_i);
        tick_i = 1'b0; cnt_ld_i = 1'b0;
        check("R10 load priority", 64'(cnt_o), 64'h1234);

        // R7: buffered write during a single-slope period waits for the wrap
        do_reset();
        mode_i = 4'd0;
        wr_ocr(1, 16'h0010);
        mode_i = 4'd3;
        tick_n(5);
        wr_ocr(1, 16'h0020);
        tick_n(12);
        check("R7 old value still active", 64'({cnt_o, ocf_o[1]}), 64'({16'h0011, 1'b1}));
        pulse_clr(4'b0010);
        // R5: clearing bit 1 only
        check("R5 clear match flag", 64'({ocf_o[1], tov_o}), 64'({1'b0, 1'b0}));
        tick_n(16'h00EF);
        check("R7 wrap", 64'({cnt_o, tov_o, oc_o[1]}), 64'({16'h0000, 1'b1, 1'b1}));
        tick_n(16'h0021);
        check("R7 new value after wrap", 64'({cnt_o, ocf_o[1], oc_o[1]}), 64'({16'h0021, 1'b1, 1'b0}));
        pulse_clr(4'b1000);
        check("R5 clear overflow", 64'({tov_o, ocf_o[1]}), 64'({1'b0, 1'b1}));

        // R8: buffered write in dual-slope waits for BOTTOM, not TOP
        do_reset();
        mode_i = 4'd0;
        wr_ocr(1, 16'h0010);
        load_cnt(16'h00FE);
        mode_i = 4'd8;
        wr_ocr(1, 16'h00FD);
        tick_n(4);
        check("R8 no transfer at TOP", 64'({cnt_o, down_o, ocf_o[1]}), 64'({16'h00FC, 1'b1, 1'b0}));
        tick_n(16'h00FC);
        check("R8 old value matched going down", 64'({cnt_o, ocf_o[1], oc_o[1]}), 64'({16'h0000, 1'b1, 1'b1}));
        tick_n(1);
        pulse_clr(4'b1111);
        tick_n(16'h00FD);
        check("R8 new value after BOTTOM", 64'({cnt_o, ocf_o, oc_o[1]}), 64'({16'h00FE, 3'b010, 1'b0}));

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule